// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital controller of a low-power 8-bit successive-approximation converter that a host reads over a three-wire serial link. The host paces the whole conversion with its serial clock. A chip-select fall, while output-enable is low, wakes the converter and starts tracking. A set number of clock falls later the input is held. After that, each clock fall resolves one result bit through an external comparator and drives that bit onto the data-out pin in the same step. The converter then shuts itself down.

The serial pins are oversampled by a fast system clock. Each SCLK or chip-select edge acts on the system-clock edge at which the new level is first sampled, and all outputs are registered. The analog track/hold, the DAC and the comparator live outside the block. The block tells them when to track, when the converter is powered, and which trial code to compare against. A select input chooses unipolar or bipolar coding. With `HAS_BIPOLAR` = 0 the same input acts as a channel select, and the coding is always straight binary.

Top module: `sar_serial_seq`

## Requirements
- R1: While reset is held, `dout`, `dout_en`, `pwr_on` and `track` are all 0.
- R2: A chip-select fall sampled while `oe_n` is low sets `pwr_on` and `track` and drives `dout` to 0. A chip-select fall while `oe_n` is high changes nothing.
- R3: On the 3rd SCLK fall after the start, `track` drops (the input is held), and `dac_code` presents the first trial value 8'h80.
- R4: `dout` stays 0 through the first three SCLK falls (the leading zeros). On falls 4 to 11 it carries the 8 result bits, MSB first. Apart from the R9 and R11 cases, `dout` changes only on an SCLK fall or at a start.
- R5: With `sel` high (unipolar), the result is straight binary: the largest code whose trial value the comparator accepts.
- R6: With `sel` low (bipolar), the result is the offset-binary SAR value with its MSB inverted, which gives two's complement.
- R7: `sel` is captured on the first SCLK rise after the start and is shown on `sel_held`. Later changes of `sel` have no effect on that conversion.
- R8: `pwr_on` drops on the 11th SCLK fall, the fall that drives the LSB.
- R9: After the LSB, `dout` holds it until the 16th SCLK rise of the frame, and then goes to 0.
- R10: While a conversion runs, chip-select may rise, and further chip-select falls neither restart tracking nor disturb the result.
- R11: While `oe_n` is high, the block is powered down and `dout_en` is 0, whatever the state. Afterwards it stays idle until a fresh chip-select fall arrives with `oe_n` low.
- R12: Once the LSB has been driven, a chip-select fall starts a new conversion immediately, even before the 16th rise.
- R13: During conversion, `dac_code` equals the bits already decided, plus a 1 in the bit under test. A bit is kept only when `cmp_hi` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; its fall starts a conversion |
| oe_n | input | 1 | Output enable, active low; high forces power-down and high-Z |
| sclk | input | 1 | Host serial clock |
| sel | input | 1 | Unipolar (1) / bipolar (0) select, or channel select |
| cmp_hi | input | 1 | Comparator: 1 when the held input is at or above `dac_code` |
| dac_code | output | 8 | Trial code to the DAC |
| track | output | 1 | Track/hold is tracking |
| pwr_on | output | 1 | Analog section powered |
| sel_held | output | 1 | Select value captured for this conversion |
| dout | output | 1 | Serial data out |
| dout_en | output | 1 | Tri-state enable for `dout` |

## Verification
The bench models the track/hold and comparator and walks full 16-clock frames with random input levels and coding. It goes after a chip-select bounce in mid-conversion, which a design that restarts on every fall would answer with a reset bit counter and garbage data. It drops output-enable mid-frame: a design that only gates the pin would keep converting and wake again on its own. It also starts a frame early, right after the LSB, which a design that waits for all 16 clocks would ignore. Changing `sel` and the analog input after they are captured exposes a design that samples them late, as a wrong MSB or wrong code.

// File: rtl/adcseq_pkg.sv
// Shared types for the serial SAR sequencer.
// Assumes: one sequencer per converter; states are encoded in two bits.
package adcseq_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,   // powered down, no frame in progress
        ST_ACQ  = 2'd1,   // powered, track/hold tracking
        ST_CONV = 2'd2,   // input held, bits being resolved
        ST_TAIL = 2'd3    // powered down, LSB still on the pin
    } seq_state_t;
endpackage

// File: rtl/sar_edge_det.sv
// Edge detector for one oversampled serial pin.
// Assumes: the pin is already synchronous to clk; IDLE is its level after reset.
module sar_edge_det #(
    parameter logic IDLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic prev;

    // Remember the level seen at the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE;
        else        prev <= din;
    end

    assign rise = !prev && din;
    assign fall = prev && !din;
endmodule

// File: rtl/sar_seq_ctrl.sv
// Frame sequencer: counts SCLK edges from a chip-select fall, places the hold
// point and the bit decisions, powers down after the LSB and ends the frame.
// Assumes: edge strobes last one clk; output-enable high overrides everything.
module sar_seq_ctrl
    import adcseq_pkg::*;
#(
    parameter int HOLD_FALL   = 3,
    parameter int DATA_W      = 8,
    parameter int FRAME_RISES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic cs_fall,
    input  logic sclk_fall,
    input  logic sclk_rise,
    input  logic sel,
    output logic start,
    output logic hold_ev,
    output logic bit_ev,
    output logic tail_end,
    output logic sel_lat,
    output logic track,
    output logic pwr_on
);
    localparam int LSB_FALL = HOLD_FALL + DATA_W;
    localparam int FCNT_W   = $clog2(LSB_FALL + 1);
    localparam int RCNT_W   = $clog2(FRAME_RISES + 1);

    seq_state_t        state;
    logic [FCNT_W-1:0] fall_cnt;
    logic [RCNT_W-1:0] rise_cnt;
    logic              rise_act;
    logic              lsb_ev;
    logic              first_rise;

    assign start      = !oe_n && cs_fall && (state == ST_OFF || state == ST_TAIL);
    assign hold_ev    = !oe_n && state == ST_ACQ && sclk_fall
                        && fall_cnt == FCNT_W'(HOLD_FALL - 1);
    assign bit_ev     = !oe_n && state == ST_CONV && sclk_fall;
    assign lsb_ev     = bit_ev && fall_cnt == FCNT_W'(LSB_FALL - 1);
    assign rise_act   = !oe_n && !start && state != ST_OFF && sclk_rise;
    assign first_rise = rise_act && rise_cnt == '0;
    assign tail_end   = rise_act && state == ST_TAIL
                        && rise_cnt == RCNT_W'(FRAME_RISES - 1);

    // State and edge counters for the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n || oe_n) begin
            state    <= ST_OFF;
            fall_cnt <= '0;
            rise_cnt <= '0;
        end else if (start) begin
            state    <= ST_ACQ;
            fall_cnt <= '0;
            rise_cnt <= '0;
        end else begin
            if (sclk_fall && (state == ST_ACQ || state == ST_CONV))
                fall_cnt <= fall_cnt + 1'b1;
            if (rise_act && rise_cnt != RCNT_W'(FRAME_RISES))
                rise_cnt <= rise_cnt + 1'b1;
            if (hold_ev)       state <= ST_CONV;
            else if (lsb_ev)   state <= ST_TAIL;
            else if (tail_end) state <= ST_OFF;
        end
    end

    // Capture the coding/channel select on the first rise of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          sel_lat <= 1'b1;
        else if (first_rise) sel_lat <= sel;
    end

    assign track  = state == ST_ACQ;
    assign pwr_on = state == ST_ACQ || state == ST_CONV;

    // R10: a chip-select fall during conversion never re-enters tracking.
    p_cs_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && cs_fall) |=> state != ST_ACQ);
    // R11: idle is left only through a chip-select fall.
    p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !cs_fall) |=> state == ST_OFF);
    // R11: output-enable high always lands in idle.
    p_oe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (state == ST_OFF && !pwr_on));
    // R3: the hold fall moves the frame into conversion.
    p_hold_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ev |=> (state == ST_CONV && !track));
    // R8: the LSB fall powers the converter down.
    p_lsb_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_ev && fall_cnt == FCNT_W'(LSB_FALL - 1)) |=> !pwr_on);
endmodule

// File: rtl/sar_trial_reg.sv
// Successive-approximation register: loads the MSB trial at hold, then keeps
// or clears the bit under test from the comparator on each decision strobe.
// Assumes: cmp_hi is valid for the current dac_code when step is high.
module sar_trial_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic              step,
    input  logic              cmp_hi,
    output logic [DATA_W-1:0] dac_code,
    output logic              cur_is_msb,
    output logic              decided
);
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] trial;

    // Trial bit walks from MSB to LSB; kept bits accumulate in result.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            result <= '0;
            trial  <= '0;
        end else if (load) begin
            result <= '0;
            trial  <= {1'b1, {(DATA_W-1){1'b0}}};
        end else if (step) begin
            if (cmp_hi) result <= result | trial;
            trial <= trial >> 1;
        end
    end

    assign dac_code   = result | trial;
    assign cur_is_msb = trial[DATA_W-1];
    assign decided    = cmp_hi;

    // R13: at most one bit is under test at any time.
    p_trial_onehot_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trial));
    // R13: a rejected trial leaves that bit cleared.
    p_reject_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cmp_hi && !clear && !load) |=> ((result & $past(trial)) == '0));
endmodule

// File: rtl/sar_dout_drv.sv
// Serial output stage: drives the leading zeros, each decided bit (MSB
// flipped in bipolar coding), holds the LSB and returns low at frame end.
// Assumes: strobes come from the sequencer in the same clk.
module sar_dout_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic start,
    input  logic bit_ev,
    input  logic tail_end,
    input  logic decided,
    input  logic is_msb,
    input  logic bipolar,
    output logic dout,
    output logic dout_en
);
    // Data pin level.
    always_ff @(posedge clk) begin
        if (!rst_n || oe_n)  dout <= 1'b0;
        else if (start)      dout <= 1'b0;
        else if (bit_ev)     dout <= decided ^ (is_msb && bipolar);
        else if (tail_end)   dout <= 1'b0;
    end

    // Tri-state enable follows output-enable.
    always_ff @(posedge clk) begin
        if (!rst_n) dout_en <= 1'b0;
        else        dout_en <= !oe_n;
    end
endmodule

// File: rtl/sar_serial_seq.sv
// Top of the serial SAR conversion sequencer. Oversamples the serial pins,
// runs the frame sequencer, the SAR register and the output stage.
// Assumes: clk is much faster than sclk and the pins are synchronous to clk.
module sar_serial_seq #(
    parameter int DATA_W      = 8,
    parameter int LEAD_ZEROS  = 4,
    parameter int FRAME_RISES = 16,
    parameter bit HAS_BIPOLAR = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              sclk,
    input  logic              sel,
    input  logic              cmp_hi,
    output logic [DATA_W-1:0] dac_code,
    output logic              track,
    output logic              pwr_on,
    output logic              sel_held,
    output logic              dout,
    output logic              dout_en
);
    localparam int HOLD_FALL = LEAD_ZEROS - 1;

    logic sclk_rise, sclk_fall, cs_rise, cs_fall;
    logic start, hold_ev, bit_ev, tail_end;
    logic decided, cur_is_msb, bipolar;

    sar_edge_det #(.IDLE(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .din(sclk), .rise(sclk_rise), .fall(sclk_fall));
    sar_edge_det #(.IDLE(1'b1)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .rise(cs_rise), .fall(cs_fall));

    sar_seq_ctrl #(
        .HOLD_FALL(HOLD_FALL), .DATA_W(DATA_W), .FRAME_RISES(FRAME_RISES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .cs_fall(cs_fall),
        .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .sel(sel),
        .start(start), .hold_ev(hold_ev), .bit_ev(bit_ev), .tail_end(tail_end),
        .sel_lat(sel_held), .track(track), .pwr_on(pwr_on));

    sar_trial_reg #(.DATA_W(DATA_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .clear(start), .load(hold_ev), .step(bit_ev),
        .cmp_hi(cmp_hi), .dac_code(dac_code), .cur_is_msb(cur_is_msb),
        .decided(decided));

    // The select input means coding only on the differential variant.
    generate
        if (HAS_BIPOLAR) begin : g_bipolar
            assign bipolar = !sel_held;
        end else begin : g_channel
            assign bipolar = 1'b0;
        end
    endgenerate

    sar_dout_drv u_out (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .start(start), .bit_ev(bit_ev),
        .tail_end(tail_end), .decided(decided), .is_msb(cur_is_msb),
        .bipolar(bipolar), .dout(dout), .dout_en(dout_en));

    // R4: without an SCLK edge, chip-select fall or output-enable, dout holds.
    p_dout_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !sclk_rise && !cs_fall && !cs_rise && !oe_n) |=> $stable(dout));
    // R11: output-enable high releases the pin and parks it low.
    p_oe_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (!dout_en && !dout));
endmodule

// File: tb/sar_serial_seq_bench.sv
module sar_serial_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       oe_n = 1'b0;
    logic       sclk = 1'b0;
    logic       sel = 1'b1;
    logic       cmp_hi;
    logic [7:0] dac_code;
    logic       track, pwr_on, sel_held, dout, dout_en;

    logic [7:0] vin = 8'h00;
    logic [7:0] held = 8'h00;
    int checks = 0;
    int errors = 0;

    always #4 clk = !clk;

    sar_serial_seq u_sar_serial_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .sclk(sclk),
        .sel(sel), .cmp_hi(cmp_hi), .dac_code(dac_code), .track(track),
        .pwr_on(pwr_on), .sel_held(sel_held), .dout(dout), .dout_en(dout_en));

    // Behavioural track/hold and comparator.
    always @(posedge clk) if (track) held <= vin;
    assign cmp_hi = held >= dac_code;

    function automatic logic [7:0] exp_code(input logic [7:0] v, input logic uni);
        return uni ? v : (v ^ 8'h80);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // One CPOL=0 frame with checks; stop_after < 16 leaves it early.
    task automatic frame(input logic [7:0] v, input logic uni, input bit midcs,
                         input bit chgv, input int stop_after);
        logic [7:0] e;
        e = exp_code(v, uni);
        sel = uni; vin = v; sclk = 1'b0;
        cs_n = 1'b1; step();
        cs_n = 1'b0; step();
        chk("R2 power-up", {pwr_on, dout, dout_en}, {1'b1, 1'b0, 1'b1});
        for (int i = 1; i <= stop_after; i++) begin
            sclk = 1'b1; step();
            if (i == 1) begin
                chk("R7 select captured", sel_held, uni);
                sel = !uni;
            end
            if (i >= 12 && i <= 15) chk("R9 LSB held", dout, e[0]);
            if (i == 16) chk("R9 low after 16th rise", dout, 1'b0);
            sclk = 1'b0; step();
            if (i <= 3) chk("R4 leading zero", dout, 1'b0);
            if (i == 3) begin
                chk("R3 held", {track, dac_code}, {1'b0, 8'h80});
                if (chgv) vin = ~v;
            end
            if (i == 4) chk("R13 trial code", dac_code, {v[7], 1'b1, 6'b0});
            if (i >= 4 && i <= 11)
                chk(uni ? "R5 unipolar bit" : "R6 bipolar bit", dout, e[11-i]);
            if (i == 11) chk("R8 auto power-down", pwr_on, 1'b0);
            if (i == 6 && midcs) begin
                cs_n = 1'b1; step();
                cs_n = 1'b0; step();
                chk("R10 CS bounce ignored", {pwr_on, track}, {1'b1, 1'b0});
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1207));
        repeat (3) step();
        chk("R1 reset state", {dout, dout_en, pwr_on, track}, 4'b0000);
        rst_n = 1'b1; step();

        // R2: a chip-select fall with output-enable high is ignored.
        oe_n = 1'b1; step();
        cs_n = 1'b0; step();
        chk("R2 ignored with OE high", {pwr_on, track, dout_en}, 3'b000);
        oe_n = 1'b0; step(); step();
        chk("R11 no wake without CS fall", pwr_on, 1'b0);
        cs_n = 1'b1; step();

        frame(8'hA5, 1'b1, 1'b0, 1'b0, 16);
        frame(8'h00, 1'b1, 1'b0, 1'b0, 16);
        frame(8'hFF, 1'b1, 1'b0, 1'b1, 16);
        frame(8'h80, 1'b0, 1'b0, 1'b0, 16);
        frame(8'h7F, 1'b0, 1'b1, 1'b1, 16);

        // R11: output-enable high mid-conversion.
        cs_n = 1'b1; step(); cs_n = 1'b0; step();
        for (int k = 0; k < 5; k++) begin
            sclk = 1'b1; step(); sclk = 1'b0; step();
        end
        oe_n = 1'b1; step();
        chk("R11 forced off", {dout_en, pwr_on, track, dout}, 4'b0000);
        oe_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b1; step(); sclk = 1'b0; step();
        end
        chk("R11 stays idle", {pwr_on, track, dout}, 3'b000);
        frame(8'h3C, 1'b1, 1'b0, 1'b0, 16);

        // R12: restart right after the LSB, before the 16th rise.
        frame(8'hC3, 1'b1, 1'b0, 1'b0, 12);
        cs_n = 1'b1; step(); cs_n = 1'b0; step();
        chk("R12 early restart", {pwr_on, track, dout}, 3'b110);
        frame(8'h5A, 1'b0, 1'b0, 1'b0, 16);

        for (int n = 0; n < 30; n++) begin
            logic [7:0] rv;
            rv = 8'($urandom);
            frame(rv, 1'($urandom), 1'($urandom), 1'($urandom), 16);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule